// File: doc/BRIEF.md
# TDM Timeslot Loopback Selector

This block sits on the transmit side of one framed TDM port that carries 32 timeslots of 8 bits each. On every bit time it decides what the transmit data line carries. It can send the bit just received from the line, which loops that bit back, or it can send the next bit played out of the jitter buffer. A port-wide loopback control loops every bit. A 32-bit mask loops only the chosen timeslots, and the other timeslots in the same frame keep their normal playout. Each port has its own instance, so any number of ports can be in loopback at the same time.

Loopback never cuts off the packet side. Every received bit is still offered to the packet transmit path, gated only by that path's own enable. Packet payload arriving for the port is still pushed into the jitter buffer unless a discard control is set. The jitter buffer is popped only on bit times that are not looped, so data held during a loopback plays out once the loopback is removed. A frame pulse and a bit strobe are inputs. Framing, clock selection and slip handling are done elsewhere.

Top module: `ts_loopback_mux`

## Requirements
- R1: While `rst_n` is low, `tx_d`, `loop_act` and the timeslot position are cleared to zero and the latched mask is cleared.
- R2: With `port_loop` high, the `rx_d` value sampled on a bit strobe appears on `tx_d` one clock after that strobe.
- R3: A bit strobe with `frm_sync` high is bit 0 of timeslot 0. The position then advances by one bit per strobe, and each timeslot lasts 8 bits. While mask bit n is set, the bits of timeslot n are looped from `rx_d` to `tx_d` one clock after their strobe.
- R4: On a strobe where the current timeslot is not looped, `jb_d` appears on `tx_d` one clock later.
- R5: `port_loop` overrides the mask: every bit is looped, whatever the mask bits are.
- R6: `slot_loop_mask` is captured only on a strobe with `frm_sync` high and applies from that bit onward. A change in the middle of a frame has no effect until the next frame pulse.
- R7: `jb_pop` is high exactly on bit strobes whose bit is not looped, and is low on every other cycle.
- R8: `pkt_vld` equals `bit_stb` and `pkt_tx_en`, and `pkt_d` carries `rx_d`, whatever the loopback state.
- R9: `jb_push` follows `pay_vld` while `pay_discard` is low, and stays low while `pay_discard` is high.
- R10: `tx_d` and `loop_act` change only in the clock after a bit strobe. `loop_act` flags that the current `tx_d` bit is a looped one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_stb | input | 1 | One-cycle strobe per TDM bit time |
| frm_sync | input | 1 | Frame pulse, valid together with the strobe for bit 0 of timeslot 0 |
| rx_d | input | 1 | Received line data bit |
| jb_d | input | 1 | Next bit played out of the jitter buffer |
| port_loop | input | 1 | Loop the whole port |
| slot_loop_mask | input | 32 | Per-timeslot loop mask, bit n for timeslot n |
| pkt_tx_en | input | 1 | Transmit enable of the packet path |
| pay_discard | input | 1 | Drop packet payload instead of buffering it |
| pay_vld | input | 1 | Packet payload bit offered to the jitter buffer |
| tx_d | output | 1 | Transmit line data bit |
| loop_act | output | 1 | Current `tx_d` bit comes from the loopback |
| jb_pop | output | 1 | Consume one jitter buffer bit |
| pkt_d | output | 1 | Received bit forwarded to the packet path |
| pkt_vld | output | 1 | Forwarded bit valid |
| jb_push | output | 1 | Write payload into the jitter buffer |

## Verification
If the timeslot position drifts, `tx_d` starts carrying `rx_d` in the wrong timeslot. This shows within one bit strobe of the first affected boundary, and `jb_pop` changes on the same strobe. If the mask is taken up too early or too late, the error appears on the first bit after a mid-frame mask change and lasts until the next frame pulse. A wrong latched selection is visible on `tx_d` and `loop_act` one clock after the strobe. The reference model compares every output on every clock, so each of these faults is seen within a cycle or two.

// File: rtl/ts_loopback_mux.sv
module ts_loopback_mux #(
  parameter int SLOTS  = 32,
  parameter int SLOT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_stb,
  input  logic             frm_sync,
  input  logic             rx_d,
  input  logic             jb_d,
  input  logic             port_loop,
  input  logic [SLOTS-1:0] slot_loop_mask,
  input  logic             pkt_tx_en,
  input  logic             pay_discard,
  input  logic             pay_vld,
  output logic             tx_d,
  output logic             loop_act,
  output logic             jb_pop,
  output logic             pkt_d,
  output logic             pkt_vld,
  output logic             jb_push
);
  localparam int SW = (SLOTS  > 1) ? $clog2(SLOTS)  : 1;
  localparam int BW = (SLOT_W > 1) ? $clog2(SLOT_W) : 1;
  localparam logic [SW-1:0] SLOT_LAST = SW'(SLOTS - 1);
  localparam logic [BW-1:0] BIT_LAST  = BW'(SLOT_W - 1);

  logic [SW-1:0]    slot_q, slot_cur;
  logic [BW-1:0]    bit_q, bit_cur;
  logic [SLOTS-1:0] mask_q, mask_cur;
  logic             looped;

  assign slot_cur = frm_sync ? '0 : slot_q;
  assign bit_cur  = frm_sync ? '0 : bit_q;
  assign mask_cur = frm_sync ? slot_loop_mask : mask_q;
  assign looped   = port_loop | mask_cur[slot_cur];

  assign jb_pop  = bit_stb & ~looped;
  assign pkt_d   = rx_d;
  assign pkt_vld = bit_stb & pkt_tx_en;
  assign jb_push = pay_vld & ~pay_discard;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q   <= '0;
      bit_q    <= '0;
      mask_q   <= '0;
      tx_d     <= 1'b0;
      loop_act <= 1'b0;
    end else if (bit_stb) begin
      tx_d     <= looped ? rx_d : jb_d;
      loop_act <= looped;
      mask_q   <= mask_cur;
      if (bit_cur == BIT_LAST) begin
        bit_q  <= '0;
        slot_q <= (slot_cur == SLOT_LAST) ? '0 : slot_cur + 1'b1;
      end else begin
        bit_q  <= bit_cur + 1'b1;
        slot_q <= slot_cur;
      end
    end
  end
endmodule

// File: rtl/ts_loopback_mux_chk.sv
module ts_loopback_mux_chk #(
  parameter int SLOTS  = 32,
  parameter int SLOT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_stb,
  input logic             frm_sync,
  input logic             rx_d,
  input logic             jb_d,
  input logic             port_loop,
  input logic [SLOTS-1:0] slot_loop_mask,
  input logic             pkt_tx_en,
  input logic             pay_discard,
  input logic             pay_vld,
  input logic             tx_d,
  input logic             loop_act,
  input logic             jb_pop,
  input logic             pkt_d,
  input logic             pkt_vld,
  input logic             jb_push
);
  p_line_loop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb && port_loop |=> tx_d == $past(rx_d) && loop_act);

  p_playout_r4: assert property (@(posedge clk) disable iff (!rst_n)
    jb_pop |=> tx_d == $past(jb_d) && !loop_act);

  p_line_priority_r5: assert property (@(posedge clk) disable iff (!rst_n)
    port_loop |-> !jb_pop);

  p_pop_on_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    jb_pop |-> bit_stb);

  p_forward_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_vld |-> bit_stb && pkt_tx_en);

  p_discard_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pay_discard |-> !jb_push);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |=> $stable(tx_d) && $stable(loop_act));
endmodule

bind ts_loopback_mux ts_loopback_mux_chk #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_chk (.*);

// File: tb/tb_ts_loopback_mux.sv
module tb_ts_loopback_mux;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_stb = 1'b0, frm_sync = 1'b0, rx_d = 1'b0, jb_d = 1'b0;
  logic port_loop = 1'b0, pkt_tx_en = 1'b0, pay_discard = 1'b0, pay_vld = 1'b0;
  logic [31:0] slot_loop_mask = '0;
  logic tx_d, loop_act, jb_pop, pkt_d, pkt_vld, jb_push;

  int tests = 0, fails = 0, cyc = 0, bitn = 0;
  logic [15:0] lfsr = 16'hACE1;

  int m_slot = 0, m_bit = 0;
  logic [31:0] m_mask = '0;
  logic m_tx = 1'b0, m_act = 1'b0, m_prev_stb = 1'b0;
  string m_tag = "R1";

  always #2 clk = ~clk;

  ts_loopback_mux dut (.*);

  function automatic int cur_slot();
    return frm_sync ? 0 : m_slot;
  endfunction
  function automatic logic [31:0] cur_mask();
    return frm_sync ? slot_loop_mask : m_mask;
  endfunction
  function automatic logic cur_loop();
    logic [31:0] mk = cur_mask();
    return port_loop || mk[cur_slot()];
  endfunction

  always @(posedge clk) begin
    m_prev_stb <= bit_stb;
    if (!rst_n) begin
      m_slot <= 0; m_bit <= 0; m_mask <= '0; m_tx <= 1'b0; m_act <= 1'b0; m_tag <= "R1";
    end else if (bit_stb) begin
      int s, b;
      logic lp;
      s = cur_slot();
      b = frm_sync ? 0 : m_bit;
      lp = cur_loop();
      m_tx   <= lp ? rx_d : jb_d;
      m_act  <= lp;
      m_mask <= cur_mask();
      if (port_loop)                              m_tag <= (cur_mask() != 0) ? "R5" : "R2";
      else if (!frm_sync && slot_loop_mask != m_mask) m_tag <= "R6";
      else                                        m_tag <= lp ? "R3" : "R4";
      if (b == 7) begin m_bit <= 0; m_slot <= (s + 1) % 32; end
      else begin m_bit <= b + 1; m_slot <= s; end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0b expected %0b", tag, cyc, act, exp);
    end
  endtask

  task automatic compare();
    string t;
    t = m_prev_stb ? m_tag : "R10";
    chk(t, tx_d, m_tx);
    chk(t, loop_act, m_act);
    chk("R7", jb_pop, bit_stb && !cur_loop());
    chk("R8", pkt_vld, bit_stb && pkt_tx_en);
    if (pkt_vld) chk("R8", pkt_d, rx_d);
    chk("R9", jb_push, pay_vld && !pay_discard);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      cyc++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      bit_stb  = (cyc % 2) == 0;
      frm_sync = bit_stb && (bitn % 256 == 0);
      if (bit_stb) bitn++;
      rx_d    = lfsr[0];
      jb_d    = lfsr[3];
      pay_vld = lfsr[7];
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", tx_d, 1'b0);
    chk("R1", loop_act, 1'b0);
    chk("R1", jb_pop, 1'b0);
    rst_n = 1'b1;
    pkt_tx_en = 1'b1;
    run(1100);
    slot_loop_mask = 32'hA50F3C81;
    run(300);
    run(1200);
    slot_loop_mask = 32'h0000FFFF;
    run(700);
    port_loop = 1'b1;
    run(1100);
    port_loop = 1'b0;
    slot_loop_mask = 32'hFFFFFFFF;
    pay_discard = 1'b1;
    pkt_tx_en = 1'b0;
    run(1100);
    slot_loop_mask = 32'h80000001;
    pay_discard = 1'b0;
    pkt_tx_en = 1'b1;
    run(900);
    bitn = 37;
    run(1300);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule